// File: doc/BRIEF.md
# Hardware Semaphore Register Bank

This block is a bank of hardware semaphores that several processors share through memory-mapped registers. No processor needs an atomic read-modify-write on the bus. Each semaphore sits in its own 32-bit word.

A processor takes a semaphore with a plain read. The read returns 0 when the semaphore was free, and the same read marks it as held. When the semaphore is already held, the read returns 1 and nothing changes. The holder writes 0 to the word to release it. A status word tells software how many semaphores the bank has, as a one-hot count in units of 32.

Several requesters share the bank. A fixed-priority arbiter lets through one access per cycle, so two requesters can never both read 0 from the same semaphore. A requester holds its request until it is granted. The response arrives one cycle after the grant.

Top module: `hwsem_bank`

## Requirements
- R1: A granted read of lock word i (byte address 0x800 + 4*i, with i below NUM_LOCKS) that finds lock i free returns 0 and leaves lock i held.
- R2: A granted read of a lock word whose lock is already held returns 1 and changes no lock state.
- R3: A granted write of 0 to a lock word frees that lock. A write of any nonzero value to a lock word changes no lock state.
- R4: An access that does not hit a lock word changes no lock state, and a read of it returns 0 (status word excepted). This covers indices NUM_LOCKS and up within byte addresses 0x800 to 0xFFC, addresses whose two low bits are not 0, and any other address.
- R5: A read of byte address 0x014 returns NUM_LOCKS/32 in bits 31:24, which is one of 1, 2, 4 or 8. It returns 1 in bit 0 once reset has completed, and 0 in every other bit. Writes to this address have no effect.
- R6: Reset frees every lock and clears every response-valid bit.
- R7: At most one requester is granted per cycle. Grants go only to requesters whose request is raised. Whenever any request is raised, the lowest-numbered raised request is granted. A requester that is not granted keeps its request raised.
- R8: rsp_vld[p] is 1 exactly in the cycle after requester p was granted. rsp_data then holds the read value, or 0 when the access was a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | NUM_REQ | Access request, one bit per requester |
| req_wr | input | NUM_REQ | 1 = write, 0 = read, per requester |
| req_addr | input | NUM_REQ*ADDR_W | Byte address, requester p in bits p*ADDR_W upward |
| req_wdata | input | NUM_REQ*32 | Write data, requester p in bits p*32 upward |
| req_gnt | output | NUM_REQ | One-hot grant, valid in the cycle of the request |
| rsp_vld | output | NUM_REQ | Response strobe, one cycle after grant |
| rsp_data | output | 32 | Read data of the granted access |

## Verification
The bench builds the bank with 64 locks and three requesters. The 12-bit address then spans 512 lock slots, so a sweep over every slot reaches both the real locks and the 448 out-of-range slots. Those out-of-range slots include the ones that would alias onto real locks if the index were truncated. Three requesters make it possible to aim two and three simultaneous accesses at one lock, and to mix a read and a release in the same cycle, which shows both the priority order and the serialization.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned STATUS_OFFS = 'h014;
  localparam int unsigned REGION_BIT  = 11;   // lock words live where this bit is the only high bit
  localparam int unsigned SLOT_W      = 9;    // word slots in the lock region
  localparam int unsigned UNIT        = 32;   // count granularity of the status field

  // Status word: count field in 31:24, ready flag in bit 0.
  function automatic logic [DATA_W-1:0] status_word(input int unsigned nlocks, input logic rdy);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[31:24] = 8'(nlocks / UNIT);
    w[0]     = rdy;
    return w;
  endfunction

  function automatic bit count_is_legal(input int unsigned nlocks);
    return (nlocks == 32) || (nlocks == 64) || (nlocks == 128) || (nlocks == 256);
  endfunction
endpackage

// File: rtl/hwsem_arb.sv
module hwsem_arb #(
  parameter int unsigned NUM_REQ = 2,
  localparam int unsigned IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] gnt,
  output logic [IW-1:0]      idx,
  output logic               any
);
  // lowest index wins: walk downward so the last hit is the lowest
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/hwsem_decode.sv
module hwsem_decode
  import hwsem_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_lock,
  output logic              hit_status,
  output logic [IDX_W-1:0]  lock_idx
);
  localparam logic [SLOT_W-1:0]             LIMIT   = SLOT_W'(NUM_LOCKS);
  localparam logic [ADDR_W-REGION_BIT-1:0]  REG_TAG = (ADDR_W-REGION_BIT)'(1);

  logic [SLOT_W-1:0] slot;
  logic              in_region;
  logic              aligned;

  always_comb begin
    slot       = addr[REGION_BIT-1:2];
    in_region  = (addr[ADDR_W-1:REGION_BIT] == REG_TAG);
    aligned    = (addr[1:0] == 2'b00);
    hit_lock   = in_region && aligned && (slot < LIMIT);
    lock_idx   = slot[IDX_W-1:0];
    hit_status = (addr == ADDR_W'(STATUS_OFFS));
  end
endmodule

// File: rtl/hwsem_lock_array.sv
module hwsem_lock_array #(
  parameter int unsigned NUM_LOCKS = 32,
  localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acq_en,
  input  logic                 rel_en,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_LOCKS-1:0] lock_q
);
  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    logic sel;
    assign sel = (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              lock_q[g] <= 1'b0;
      else if (sel && acq_en)  lock_q[g] <= 1'b1;
      else if (sel && rel_en)  lock_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/hwsem_bank.sv
module hwsem_bank
  import hwsem_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned NUM_REQ   = 2,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_REQ-1:0]          req_vld,
  input  logic [NUM_REQ-1:0]          req_wr,
  input  logic [NUM_REQ*ADDR_W-1:0]   req_addr,
  input  logic [NUM_REQ*DATA_W-1:0]   req_wdata,
  output logic [NUM_REQ-1:0]          req_gnt,
  output logic [NUM_REQ-1:0]          rsp_vld,
  output logic [DATA_W-1:0]           rsp_data
);
  localparam int unsigned IDX_W = $clog2(NUM_LOCKS);
  localparam int unsigned IW    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  if (!count_is_legal(NUM_LOCKS)) begin : g_bad_count
    initial $error("NUM_LOCKS must be 32, 64, 128 or 256");
  end

  // arbitration
  logic [IW-1:0] gnt_idx;
  logic          gnt_any;

  hwsem_arb #(.NUM_REQ(NUM_REQ)) u_arb (
    .req (req_vld),
    .gnt (req_gnt),
    .idx (gnt_idx),
    .any (gnt_any)
  );

  // selected access
  logic [ADDR_W-1:0] sel_addr;
  logic              sel_wr;
  logic [DATA_W-1:0] sel_wdata;

  always_comb begin
    sel_addr  = req_addr[gnt_idx*ADDR_W +: ADDR_W];
    sel_wr    = req_wr[gnt_idx];
    sel_wdata = req_wdata[gnt_idx*DATA_W +: DATA_W];
  end

  logic             hit_lock;
  logic             hit_status;
  logic [IDX_W-1:0] lock_idx;

  hwsem_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_dec (
    .addr       (sel_addr),
    .hit_lock   (hit_lock),
    .hit_status (hit_status),
    .lock_idx   (lock_idx)
  );

  // lock state and named events
  logic [NUM_LOCKS-1:0] lock_q;
  logic cur_held;
  logic acq_evt, busy_rd_evt, rel_en, rel_evt, nop_evt, stat_evt;

  always_comb begin
    cur_held    = lock_q[lock_idx];
    acq_evt     = gnt_any && !sel_wr && hit_lock && !cur_held;
    busy_rd_evt = gnt_any && !sel_wr && hit_lock &&  cur_held;
    rel_en      = gnt_any &&  sel_wr && hit_lock && (sel_wdata == '0);
    rel_evt     = rel_en && cur_held;
    nop_evt     = gnt_any && (sel_wr ? (!hit_lock || (sel_wdata != '0)) : !hit_lock);
    stat_evt    = gnt_any && !sel_wr && hit_status;
  end

  hwsem_lock_array #(.NUM_LOCKS(NUM_LOCKS)) u_locks (
    .clk    (clk),
    .rst_n  (rst_n),
    .acq_en (acq_evt),
    .rel_en (rel_en),
    .idx    (lock_idx),
    .lock_q (lock_q)
  );

  // read data
  logic              ready_q;
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    if (sel_wr)          rd_val = '0;
    else if (hit_status) rd_val = status_word(NUM_LOCKS, ready_q);
    else if (hit_lock)   rd_val = DATA_W'(cur_held);
    else                 rd_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      rsp_vld  <= '0;
      rsp_data <= '0;
    end else begin
      ready_q  <= 1'b1;
      rsp_vld  <= req_gnt;
      rsp_data <= gnt_any ? rd_val : '0;
    end
  end
endmodule

// File: rtl/hwsem_chk.sv
module hwsem_chk #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned NUM_REQ   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_REQ-1:0]   req_vld,
  input logic [NUM_REQ-1:0]   req_gnt,
  input logic [NUM_REQ-1:0]   rsp_vld,
  input logic [31:0]          rsp_data,
  input logic [NUM_LOCKS-1:0] lock_q,
  input logic                 acq_evt,
  input logic                 busy_rd_evt,
  input logic                 rel_evt,
  input logic                 nop_evt,
  input logic                 stat_evt
);
  logic first_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= 1'b1;
    else        first_q <= 1'b0;
  end

  AST_RESET_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |-> (lock_q == '0) && (rsp_vld == '0)); // R6

  AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_gnt & ~req_vld) == '0); // R7

  AST_GNT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_vld) |-> ($countones(req_gnt) == 1)); // R7

  AST_RSP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_vld == $past(req_gnt))); // R8

  AST_ACQ_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    acq_evt |=> (rsp_data == 32'd0) && ($countones(lock_q) == $past($countones(lock_q)) + 1)); // R1

  AST_HELD_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rd_evt |=> (rsp_data == 32'd1) && $stable(lock_q)); // R2

  AST_REL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> ($countones(lock_q) + 1 == $past($countones(lock_q)))); // R3

  AST_NOP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    nop_evt |=> $stable(lock_q)); // R4

  AST_STATUS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    stat_evt |=> ($countones(rsp_data[27:24]) == 1) && (rsp_data[31:28] == 4'd0)
                 && (rsp_data[23:1] == '0) && rsp_data[0]); // R5
endmodule

bind hwsem_bank hwsem_chk #(.NUM_LOCKS(NUM_LOCKS), .NUM_REQ(NUM_REQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_vld     (req_vld),
  .req_gnt     (req_gnt),
  .rsp_vld     (rsp_vld),
  .rsp_data    (rsp_data),
  .lock_q      (lock_q),
  .acq_evt     (acq_evt),
  .busy_rd_evt (busy_rd_evt),
  .rel_evt     (rel_evt),
  .nop_evt     (nop_evt),
  .stat_evt    (stat_evt)
);

// File: tb/sim_hwsem_bank.sv
`timescale 1ns/1ps
module sim_hwsem_bank;
  localparam int NL = 64;
  localparam int NR = 3;
  localparam int AW = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NR-1:0]     vld = '0;
  logic [NR-1:0]     wr = '0;
  logic [NR*AW-1:0]  addr = '0;
  logic [NR*32-1:0]  wd = '0;
  logic [NR-1:0]     gnt;
  logic [NR-1:0]     rvld;
  logic [31:0]       rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  hwsem_bank #(.NUM_LOCKS(NL), .NUM_REQ(NR), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(vld), .req_wr(wr), .req_addr(addr),
    .req_wdata(wd), .req_gnt(gnt), .rsp_vld(rvld), .rsp_data(rdata)
  );

  function automatic logic [AW-1:0] lk(input int i);
    return AW'('h800 + 4 * i);
  endfunction

  function automatic logic [31:0] exp_status();
    return ((NL / 32) << 24) | 32'd1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input int p, input logic w, input logic [AW-1:0] a, input logic [31:0] d);
    vld[p] = 1'b1;
    wr[p]  = w;
    addr[p*AW +: AW] = a;
    wd[p*32 +: 32]   = d;
  endtask

  // single access on requester p; returns response data
  task automatic access(input int p, input logic w, input logic [AW-1:0] a,
                        input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    drive(p, w, a, d);
    @(negedge clk);
    vld[p] = 1'b0;
    check("R8 rsp strobe", 32'(rvld), 32'(1 << p));
    r = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check("R6 rsp idle in reset", 32'(rvld), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 rsp idle after reset", 32'(rvld), 32'd0);

    // R5 status and ignored write
    access(0, 1'b0, AW'('h014), 32'd0, r); check("R5 status", r, exp_status());
    access(1, 1'b1, AW'('h014), 32'h0, r); check("R8 write data zero", r, 32'd0);
    access(2, 1'b0, AW'('h014), 32'd0, r); check("R5 status after write", r, exp_status());

    // R1/R4 first sweep of all slots
    for (int i = 0; i < 512; i++) begin
      access(i % NR, 1'b0, lk(i), 32'd0, r);
      check(i < NL ? "R1 free read" : "R4 out of range read", r, 32'd0);
    end
    // R2/R4 second sweep
    for (int i = 0; i < 512; i++) begin
      access((i + 1) % NR, 1'b0, lk(i), 32'd0, r);
      check(i < NL ? "R2 held read" : "R4 out of range read", r, (i < NL) ? 32'd1 : 32'd0);
    end

    // R3 nonzero writes ignored
    for (int i = 0; i < NL; i++) begin
      access(0, 1'b1, lk(i), (i % 2 == 0) ? 32'hFFFF_FFFF : 32'(i + 1), r);
    end
    for (int i = 0; i < NL; i++) begin
      access(1, 1'b0, lk(i), 32'd0, r); check("R3 nonzero write ignored", r, 32'd1);
    end

    // R4 aliasing, misaligned and status writes of 0
    for (int i = NL; i < 2 * NL; i++) access(2, 1'b1, lk(i), 32'd0, r);
    access(0, 1'b1, AW'('h801), 32'd0, r);
    access(0, 1'b1, AW'('h014), 32'd0, r);
    access(0, 1'b1, AW'('h400), 32'd0, r);
    for (int i = 0; i < NL; i++) begin
      access(1, 1'b0, lk(i), 32'd0, r); check("R4 no alias release", r, 32'd1);
    end
    access(0, 1'b0, AW'('h806), 32'd0, r); check("R4 misaligned read", r, 32'd0);
    access(0, 1'b0, AW'('h000), 32'd0, r); check("R4 unmapped read", r, 32'd0);

    // R3 release even locks
    for (int i = 0; i < NL; i += 2) access(2, 1'b1, lk(i), 32'd0, r);
    for (int i = 0; i < NL; i++) begin
      access(i % NR, 1'b0, lk(i), 32'd0, r);
      check((i % 2 == 0) ? "R3 released reads free" : "R2 still held", r, (i % 2 == 0) ? 32'd0 : 32'd1);
    end

    // R7 three-way contention on lock 5
    access(0, 1'b1, lk(5), 32'd0, r);
    @(negedge clk);
    for (int p = 0; p < NR; p++) drive(p, 1'b0, lk(5), 32'd0);
    #1 check("R7 grant lowest", 32'(gnt), 32'b001);
    for (int p = 0; p < NR; p++) begin
      @(negedge clk);
      check("R8 serial strobe", 32'(rvld), 32'(1 << p));
      check(p == 0 ? "R7 first winner takes" : "R7 later requester sees held", rdata, (p == 0) ? 32'd0 : 32'd1);
      vld[p] = 1'b0;
      if (p < NR - 1) begin
        #1 check("R7 held request granted next", 32'(gnt), 32'(1 << (p + 1)));
      end
    end

    // R7 read and release of lock 7 in the same cycle
    @(negedge clk);
    drive(1, 1'b0, lk(7), 32'd0);
    drive(2, 1'b1, lk(7), 32'd0);
    #1 check("R7 priority mixed", 32'(gnt), 32'b010);
    @(negedge clk);
    check("R8 read first", 32'(rvld), 32'b010);
    check("R2 read before release", rdata, 32'd1);
    vld[1] = 1'b0;
    @(negedge clk);
    check("R8 write next", 32'(rvld), 32'b100);
    vld[2] = 1'b0;
    access(0, 1'b0, lk(7), 32'd0, r); check("R3 released by write", r, 32'd0);

    // R6 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R6 rsp cleared", 32'(rvld), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NL; i++) begin
      access(i % NR, 1'b0, lk(i), 32'd0, r); check("R6 reset frees", r, 32'd0);
    end
    access(1, 1'b0, AW'('h014), 32'd0, r); check("R5 status after reset", r, exp_status());

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule